// File: doc/BRIEF.md
# Bus-Master Disk DMA Register File

This block is the software-visible register front end of a two-channel bus-master disk DMA controller. It sits on a simple synchronous register bus and decodes a 16-byte I/O window. The window holds one 8-byte group per channel. Each group has a command byte, a status byte and a 32-bit descriptor-table pointer. The block does not move data. It hands the start and direction bits to an external DMA engine and records the engine's busy, error and completion events in the status byte.

Channel 0 (primary) occupies window offsets 0..7 and channel 1 (secondary) occupies offsets 8..15. In each group, offsets 0..3 form the command/status sub-block and offsets 4..7 form the descriptor pointer. The command/status sub-block only accepts byte-wide accesses. The pointer accepts byte, word and dword accesses. The block also drives the fixed reset values of three PCI configuration fields as constant outputs.

Bus protocol: `size_i` takes 0 for a byte, 1 for a word, 2 for a dword and 3 as a reserved code. Write data is right-aligned in `wdata_i`. Read data is right-aligned in `rdata_o`. `rdata_o` is registered, so it reflects the address and size presented in the previous cycle and the register state from before that cycle's write.

Top module: `bmdma_regs`

## Requirements
- R1: Address bit 3 selects the channel (0 primary, 1 secondary). Address bit 2 selects the descriptor pointer (1) or the command/status sub-block (0).
- R2: A byte read of the command/status sub-block at low offset 0 returns the command byte and at offset 2 returns the status byte. Offsets 1 and 3 return 0xFF. Read data appears one cycle after the address is presented.
- R3: In the command/status sub-block, a word read returns 0x0000FFFF and a dword or reserved-size read returns 0xFFFFFFFF. Any non-byte write to that sub-block changes nothing.
- R4: A byte write to offset 0 stores bit 0 (start, driven on `start_o`) and bit 3 (direction, driven on `dir_o`). All other command bits read as 0.
- R5: Status bits 6:5 are plain read/write. Bits 7, 4 and 3 always read as 0.
- R6: Status bits 1 (error) and 2 (interrupt) are cleared by writing 1 to them with a byte write to offset 2. Writing 0 keeps them.
- R7: Status bit 0 (active) follows `busy_i` of its channel with one cycle of delay. Software writes do not change it.
- R8: A one-cycle pulse on `err_i` sets status bit 1 and a pulse on `done_i` sets status bit 2. When a set and a software clear hit the same cycle, the bit ends up set.
- R9: Byte writes to offsets 1 and 3 of the command/status sub-block have no effect.
- R10: The descriptor pointer takes byte, word or dword writes on the byte lanes selected by offset and size. Its bits 1:0 always read 0. Reads return the pointer shifted right by 8 times the offset and masked to the access width.
- R11: After reset, command, status and pointer are 0 in every channel. `cfg_cmd_o` is 0x0000, `cfg_sts_o` is 0x0280 (fast back-to-back capable, medium select timing) and `cfg_bar_o` is 0x01 (I/O space).
- R12: A write to one channel leaves every register of the other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 4 | Byte address within the window |
| size_i | input | 2 | Access size: 0 byte, 1 word, 2 dword, 3 reserved |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data, right-aligned |
| rdata_o | output | 32 | Registered read data |
| busy_i | input | 2 | Per-channel engine-active level |
| err_i | input | 2 | Per-channel error set pulse |
| done_i | input | 2 | Per-channel completion set pulse |
| start_o | output | 2 | Per-channel start/stop bit |
| dir_o | output | 2 | Per-channel transfer direction bit |
| cfg_cmd_o | output | 16 | PCI command word reset value |
| cfg_sts_o | output | 16 | PCI status word reset value |
| cfg_bar_o | output | 8 | Low byte of the bus-master base-address reset value |

## Verification
The hardest case to reach from the ports is a hardware set pulse landing in the same cycle as a software write-one-to-clear of that bit. The bench sets this up by asserting `done_i` in the very cycle of the status write strobe, then reads the status back. The active bit is handled the same way: the bench raises `busy_i` and then tries to overwrite the bit from software. This shows that the bit belongs to the engine.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } acc_size_e;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;

  localparam int STS_ACT_BIT = 0;
  localparam int STS_ERR_BIT = 1;
  localparam int STS_IRQ_BIT = 2;
  localparam int STS_RW_LO   = 5;
  localparam int STS_RW_HI   = 6;

  localparam logic [1:0] OFF_CMD = 2'd0;
  localparam logic [1:0] OFF_STS = 2'd2;

  localparam logic [15:0] CFG_CMD_RST = 16'h0000;
  localparam logic [15:0] CFG_STS_RST = 16'h0280;
  localparam logic [7:0]  CFG_BAR_RST = 8'h01;

  function automatic logic [3:0] lane_en(acc_size_e sz, logic [1:0] off);
    logic [3:0] base;
    case (sz)
      SZ_BYTE:  base = 4'b0001;
      SZ_WORD:  base = 4'b0011;
      SZ_DWORD: base = 4'b1111;
      default:  base = 4'b0000;
    endcase
    return base << off;
  endfunction

  function automatic logic [31:0] width_mask(acc_size_e sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_WORD: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/bmdma_tbl_reg.sv
module bmdma_tbl_reg
  import bmdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_i,
  input  acc_size_e size_i,
  input  logic [1:0] off_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] tbl_o
);
  localparam int NB = DW / 8;

  logic [NB-1:0] be;
  logic [DW-1:0] lane_data;
  logic [DW-1:0] tbl_q, tbl_d;

  assign be        = NB'(lane_en(size_i, off_i));
  assign lane_data = wdata_i << (8 * off_i);

  always_comb begin
    tbl_d = tbl_q;
    for (int b = 0; b < NB; b++) begin
      if (wr_i && be[b]) tbl_d[8*b +: 8] = lane_data[8*b +: 8];
    end
    tbl_d[1:0] = 2'b00; // dword-aligned table pointer
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tbl_q <= '0;
    else         tbl_q <= tbl_d;
  end

  assign tbl_o = tbl_q;
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      hit_i,
  input  logic      tbl_sel_i,
  input  logic [1:0] off_i,
  input  acc_size_e size_i,
  input  logic [DW-1:0] wdata_i,
  input  logic      busy_i,
  input  logic      err_i,
  input  logic      done_i,
  output logic [7:0] cmd_o,
  output logic [7:0] sts_o,
  output logic [DW-1:0] tbl_o,
  output logic      start_o,
  output logic      dir_o
);
  logic byte_cs;
  logic cmd_wr, sts_wr;
  logic start_q, dir_q;
  logic act_q, err_q, irq_q;
  logic [1:0] rw_q;

  assign byte_cs = hit_i && !tbl_sel_i && (size_i == SZ_BYTE);
  assign cmd_wr  = byte_cs && (off_i == OFF_CMD);
  assign sts_wr  = byte_cs && (off_i == OFF_STS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      dir_q   <= 1'b0;
      act_q   <= 1'b0;
      err_q   <= 1'b0;
      irq_q   <= 1'b0;
      rw_q    <= 2'b00;
    end else begin
      act_q <= busy_i;
      if (cmd_wr) begin
        start_q <= wdata_i[CMD_START_BIT];
        dir_q   <= wdata_i[CMD_DIR_BIT];
      end
      if (sts_wr) rw_q <= wdata_i[STS_RW_HI:STS_RW_LO];
      // hardware set beats software clear
      err_q <= err_i  || (err_q && !(sts_wr && wdata_i[STS_ERR_BIT]));
      irq_q <= done_i || (irq_q && !(sts_wr && wdata_i[STS_IRQ_BIT]));
    end
  end

  always_comb begin
    cmd_o = '0;
    cmd_o[CMD_START_BIT] = start_q;
    cmd_o[CMD_DIR_BIT]   = dir_q;
    sts_o = '0;
    sts_o[STS_ACT_BIT] = act_q;
    sts_o[STS_ERR_BIT] = err_q;
    sts_o[STS_IRQ_BIT] = irq_q;
    sts_o[STS_RW_HI:STS_RW_LO] = rw_q;
  end

  bmdma_tbl_reg #(.DW(DW)) u_tbl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (hit_i && tbl_sel_i),
    .size_i (size_i),
    .off_i  (off_i),
    .wdata_i(wdata_i),
    .tbl_o  (tbl_o)
  );

  assign start_o = start_q;
  assign dir_o   = dir_q;
endmodule

// File: rtl/bmdma_rdmux.sv
module bmdma_rdmux
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 32,
  parameter int AW     = 4
) (
  input  logic [AW-1:0] addr_i,
  input  acc_size_e     size_i,
  input  logic [NUM_CH-1:0][7:0]    cmd_i,
  input  logic [NUM_CH-1:0][7:0]    sts_i,
  input  logic [NUM_CH-1:0][DW-1:0] tbl_i,
  output logic [DW-1:0] rdata_o
);
  localparam int CW = AW - 3;

  logic [CW-1:0] ch;
  logic [1:0]    off;
  logic [DW-1:0] mask;

  assign ch   = addr_i[AW-1:3];
  assign off  = addr_i[1:0];
  assign mask = DW'(width_mask(size_i));

  always_comb begin
    rdata_o = '1;
    if (int'(ch) < NUM_CH) begin
      if (addr_i[2]) begin
        rdata_o = (tbl_i[ch] >> (8 * off)) & mask;
      end else if (size_i != SZ_BYTE) begin
        rdata_o = mask;
      end else begin
        case (off)
          OFF_CMD: rdata_o = DW'(cmd_i[ch]);
          OFF_STS: rdata_o = DW'(sts_i[ch]);
          default: rdata_o = DW'(8'hFF);
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DW     = 32,
  localparam int AW    = $clog2(NUM_CH) + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        size_i,
  input  logic              wr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic [NUM_CH-1:0] busy_i,
  input  logic [NUM_CH-1:0] err_i,
  input  logic [NUM_CH-1:0] done_i,
  output logic [NUM_CH-1:0] start_o,
  output logic [NUM_CH-1:0] dir_o,
  output logic [15:0]       cfg_cmd_o,
  output logic [15:0]       cfg_sts_o,
  output logic [7:0]        cfg_bar_o
);
  acc_size_e sz;
  logic [NUM_CH-1:0][7:0]    cmd_all;
  logic [NUM_CH-1:0][7:0]    sts_all;
  logic [NUM_CH-1:0][DW-1:0] tbl_all;
  logic [DW-1:0] rdata_d, rdata_q;

  assign sz = acc_size_e'(size_i);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = wr_i && (int'(addr_i[AW-1:3]) == c);

    bmdma_chan #(.DW(DW)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .hit_i    (hit),
      .tbl_sel_i(addr_i[2]),
      .off_i    (addr_i[1:0]),
      .size_i   (sz),
      .wdata_i  (wdata_i),
      .busy_i   (busy_i[c]),
      .err_i    (err_i[c]),
      .done_i   (done_i[c]),
      .cmd_o    (cmd_all[c]),
      .sts_o    (sts_all[c]),
      .tbl_o    (tbl_all[c]),
      .start_o  (start_o[c]),
      .dir_o    (dir_o[c])
    );
  end

  bmdma_rdmux #(.NUM_CH(NUM_CH), .DW(DW), .AW(AW)) u_rdmux (
    .addr_i (addr_i),
    .size_i (sz),
    .cmd_i  (cmd_all),
    .sts_i  (sts_all),
    .tbl_i  (tbl_all),
    .rdata_o(rdata_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rdata_d;
  end

  assign rdata_o   = rdata_q;
  assign cfg_cmd_o = CFG_CMD_RST;
  assign cfg_sts_o = CFG_STS_RST;
  assign cfg_bar_o = CFG_BAR_RST;
endmodule

// File: rtl/bmdma_regs_chk.sv
module bmdma_regs_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [3:0]  addr_i,
  input logic [1:0]  size_i,
  input logic        wr_i,
  input logic [3:0]  wd_i,
  input logic [31:0] rdata_o,
  input logic        busy0_i,
  input logic        err0_i,
  input logic        done0_i,
  input logic        start0_o,
  input logic [2:0]  sts0_i
);
  assert_cmd_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i == 2'd0 && addr_i == 4'h0) |=> (start0_o == $past(wd_i[0])));

  assert_wide_wr_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i != 2'd0 && addr_i[3:2] == 2'b00) |=> $stable(start0_o));

  assert_other_ch_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[3]) |=> $stable(start0_o));

  assert_pad_byte_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd0 && !addr_i[2] && addr_i[0]) |=> (rdata_o == 32'h0000_00FF));

  assert_wide_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == 2'd1 && !addr_i[2]) |=> (rdata_o == 32'h0000_FFFF));

  assert_done_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done0_i |=> sts0_i[2]);

  assert_err_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err0_i |=> sts0_i[1]);

  assert_irq_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i == 2'd0 && addr_i == 4'h2 && wd_i[2] && !done0_i) |=> !sts0_i[2]);

  assert_err_w1c_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && size_i == 2'd0 && addr_i == 4'h2 && wd_i[1] && !err0_i) |=> !sts0_i[1]);

  assert_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> (sts0_i[0] == $past(busy0_i)));
endmodule

bind bmdma_regs bmdma_regs_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .addr_i  (addr_i),
  .size_i  (size_i),
  .wr_i    (wr_i),
  .wd_i    (wdata_i[3:0]),
  .rdata_o (rdata_o),
  .busy0_i (busy_i[0]),
  .err0_i  (err_i[0]),
  .done0_i (done_i[0]),
  .start0_o(start_o[0]),
  .sts0_i  (sts_all[0][2:0])
);

// File: tb/sim_bmdma_regs.sv
`timescale 1ns/1ps
module sim_bmdma_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  busy = '0, err = '0, done = '0;
  logic [1:0]  start, dir;
  logic [15:0] cfg_cmd, cfg_sts;
  logic [7:0]  cfg_bar;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  bmdma_regs u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .size_i(size), .wr_i(wr),
    .wdata_i(wdata), .rdata_o(rdata), .busy_i(busy), .err_i(err), .done_i(done),
    .start_o(start), .dir_o(dir), .cfg_cmd_o(cfg_cmd), .cfg_sts_o(cfg_sts),
    .cfg_bar_o(cfg_bar)
  );

  // {wr, addr, size, data (write data or expected read), req}
  localparam int NV = 32;
  localparam logic [46:0] VEC [NV] = '{
    {1'b1, 4'h0, 2'd0, 32'h0000_00FF, 8'd4},  // R4 cmd write
    {1'b0, 4'h0, 2'd0, 32'h0000_0009, 8'd4},  // R4 only start/dir kept
    {1'b0, 4'h2, 2'd0, 32'h0000_0000, 8'd5},  // R5
    {1'b1, 4'h2, 2'd0, 32'h0000_00FF, 8'd5},  // R5
    {1'b0, 4'h2, 2'd0, 32'h0000_0060, 8'd5},  // R5
    {1'b0, 4'h1, 2'd0, 32'h0000_00FF, 8'd2},  // R2 pad
    {1'b0, 4'h3, 2'd0, 32'h0000_00FF, 8'd2},  // R2 pad
    {1'b0, 4'h0, 2'd1, 32'h0000_FFFF, 8'd3},  // R3 word read
    {1'b0, 4'h2, 2'd2, 32'hFFFF_FFFF, 8'd3},  // R3 dword read
    {1'b1, 4'h0, 2'd1, 32'h0000_0000, 8'd3},  // R3 word write dropped
    {1'b0, 4'h0, 2'd0, 32'h0000_0009, 8'd3},  // R3
    {1'b1, 4'h4, 2'd2, 32'h1234_5677, 8'd10}, // R10
    {1'b0, 4'h4, 2'd2, 32'h1234_5674, 8'd10}, // R10 low bits zero
    {1'b1, 4'h5, 2'd0, 32'h0000_00AB, 8'd10}, // R10 byte lane 1
    {1'b0, 4'h4, 2'd2, 32'h1234_AB74, 8'd10}, // R10
    {1'b0, 4'h6, 2'd1, 32'h0000_1234, 8'd10}, // R10 upper word
    {1'b1, 4'hE, 2'd1, 32'h0000_BEEF, 8'd1},  // R1 ch1 pointer
    {1'b0, 4'hC, 2'd2, 32'hBEEF_0000, 8'd1},  // R1
    {1'b0, 4'h4, 2'd2, 32'h1234_AB74, 8'd12}, // R12 ch0 untouched
    {1'b0, 4'h8, 2'd0, 32'h0000_0000, 8'd12}, // R12 ch1 cmd
    {1'b1, 4'h1, 2'd0, 32'h0000_0000, 8'd9},  // R9
    {1'b0, 4'h0, 2'd0, 32'h0000_0009, 8'd9},  // R9
    {1'b1, 4'h3, 2'd0, 32'h0000_0000, 8'd9},  // R9
    {1'b0, 4'h2, 2'd0, 32'h0000_0060, 8'd9},  // R9
    {1'b1, 4'h8, 2'd0, 32'h0000_0008, 8'd4},  // R4 ch1 dir
    {1'b0, 4'h8, 2'd0, 32'h0000_0008, 8'd4},  // R4
    {1'b0, 4'h0, 2'd0, 32'h0000_0009, 8'd12}, // R12
    {1'b1, 4'h2, 2'd0, 32'h0000_0098, 8'd5},  // R5 reserved bits
    {1'b0, 4'h2, 2'd0, 32'h0000_0000, 8'd5},  // R5
    {1'b0, 4'h5, 2'd0, 32'h0000_00AB, 8'd10}, // R10 byte read
    {1'b1, 4'h0, 2'd3, 32'h0000_0000, 8'd3},  // R3 reserved size
    {1'b0, 4'h0, 2'd0, 32'h0000_0009, 8'd3}   // R3
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req, input string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic do_write(input logic [3:0] a, input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; size = s; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic do_read(input logic [3:0] a, input logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    wr = 1'b0; addr = a; size = s;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic pulse(ref logic [1:0] sig, input int c);
    @(negedge clk);
    sig[c] = 1'b1;
    @(negedge clk);
    sig[c] = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset values
    check({16'h0, cfg_cmd}, 32'h0000_0000, 11, "cfg command");
    check({16'h0, cfg_sts}, 32'h0000_0280, 11, "cfg status");
    check({24'h0, cfg_bar}, 32'h0000_0001, 11, "cfg bar");
    for (int a = 0; a < 16; a += 8) begin
      do_read(4'(a),     2'd0, r); check(r, 32'h0, 11, "reset cmd");
      do_read(4'(a + 2), 2'd0, r); check(r, 32'h0, 11, "reset status");
      do_read(4'(a + 4), 2'd2, r); check(r, 32'h0, 11, "reset pointer");
    end

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][46]) do_write(VEC[i][45:42], VEC[i][41:40], VEC[i][39:8]);
      else begin
        do_read(VEC[i][45:42], VEC[i][41:40], r);
        check(r, VEC[i][39:8], int'(VEC[i][7:0]), $sformatf("vector %0d", i));
      end
    end
    check({30'h0, start}, 32'h1, 4, "start_o");
    check({30'h0, dir},   32'h3, 4, "dir_o");

    // R8 hardware sets
    pulse(err, 0);
    do_read(4'h2, 2'd0, r); check(r, 32'h02, 8, "err pulse sets bit1");
    pulse(done, 0);
    do_read(4'h2, 2'd0, r); check(r, 32'h06, 8, "done pulse sets bit2");
    // R6 W1C
    do_write(4'h2, 2'd0, 32'h02);
    do_read(4'h2, 2'd0, r); check(r, 32'h04, 6, "clear err only");
    // R8 set beats clear in the same cycle
    @(negedge clk);
    wr = 1'b1; addr = 4'h2; size = 2'd0; wdata = 32'h04; done[0] = 1'b1;
    @(negedge clk);
    wr = 1'b0; done[0] = 1'b0;
    do_read(4'h2, 2'd0, r); check(r, 32'h04, 8, "set wins over clear");
    do_write(4'h2, 2'd0, 32'h04);
    do_read(4'h2, 2'd0, r); check(r, 32'h00, 6, "clear irq");

    // R7 active bit owned by hardware
    @(negedge clk); busy[1] = 1'b1;
    do_read(4'hA, 2'd0, r); check(r, 32'h01, 7, "active follows busy");
    do_write(4'hA, 2'd0, 32'h00);
    do_read(4'hA, 2'd0, r); check(r, 32'h01, 7, "active ignores write");
    do_read(4'h2, 2'd0, r); check(r, 32'h00, 12, "ch0 active unaffected");
    @(negedge clk); busy[1] = 1'b0;
    do_read(4'hA, 2'd0, r); check(r, 32'h00, 7, "active drops");

    // R11 reset mid-run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    check({30'h0, start}, 32'h0, 11, "start after reset");
    do_read(4'h0, 2'd0, r); check(r, 32'h0, 11, "cmd after reset");
    do_read(4'h4, 2'd2, r); check(r, 32'h0, 11, "pointer after reset");
    do_read(4'hC, 2'd2, r); check(r, 32'h0, 11, "ch1 pointer after reset");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule